// File: doc/BRIEF.md
# Debug Hardware Breakpoint Unit

This block sits beside a CPU core and gives a debugger control over execution. It watches the program counter at every instruction boundary and watches each data-bus access. When an enabled breakpoint slot matches, it stops the CPU at an instruction boundary and records which slot caused the stop. Each slot is configured through a simple write port. A slot picks one of three kinds: program counter, data read or data write. A data slot also picks one of four address spaces, a target address and, if wanted, a required data byte.

The debugger can run, halt, step one instruction or skip one instruction. Step and skip count boundaries reported by the CPU on `insn_bnd`. That input pulses for one cycle when an instruction starts, and `pc` then holds that instruction's address. When the CPU resumes from a stop, a program-counter match at the very first boundary is ignored. This lets execution leave the breakpoint it stopped on. When `dbg_en` is low, all matching is idle and the CPU runs freely.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: An enabled slot of kind 0 (program counter) whose address equals `pc` on an `insn_bnd` cycle makes `cpu_halt` high after the next clock edge. At the same edge `hit_valid` goes high and `hit_slot` shows that slot's index.
- R2: An enabled slot of kind 1 matches only bus reads (`bus_write`=0), and kind 2 matches only bus writes (`bus_write`=1), at its address. A matching access causes no stop at once. The stop comes at the next `insn_bnd`, and `hit_slot` names the slot.
- R3: When a data slot has its data-match bit set, an access matches only if `bus_data` equals the slot's data byte. With the bit clear, any data value matches.
- R4: A data slot matches only accesses whose `bus_space` equals its own space. The encodings are 0 program memory, 1 internal data, 2 special function registers and 3 external data.
- R5: When several program-counter slots match at one boundary, the lowest index is reported. A data match pending from the previous instruction takes precedence over a program-counter match at the same boundary.
- R6: `cmd_halt` while running stops the CPU after the next edge and leaves `hit_valid` low.
- R7: `cmd_run` while halted clears `cpu_halt` and `hit_valid` after the next edge. A program-counter match at the first boundary afterwards is ignored, and later boundaries match normally.
- R8: `cmd_step` while halted releases the CPU with `cpu_skip` low. The CPU halts again at the second boundary after release, even without a match.
- R9: `cmd_skip` while halted releases the CPU with `cpu_skip` high. `cpu_skip` stays high until the CPU halts again at the second boundary after release.
- R10: While `dbg_en` is low, `cpu_halt`, `cpu_skip` and `hit_valid` are low, commands are ignored and no slot matches. Slot configuration may still be written.
- R11: After reset the CPU is running, `cpu_skip` and `hit_valid` are low, and every slot is disabled.
- R12: A slot with its enable bit clear, or with kind 3, never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug enable; low idles all matching |
| cfg_we | input | 1 | Write strobe for one slot's configuration |
| cfg_slot | input | SLOT_IW | Slot index written |
| cfg_enable | input | 1 | Slot enable |
| cfg_space | input | 2 | Address space (0 prog, 1 idata, 2 SFR, 3 xdata) |
| cfg_kind | input | 2 | 0 PC, 1 read, 2 write, 3 off |
| cfg_dmatch | input | 1 | Require data value match |
| cfg_addr | input | ADDR_W | Target address |
| cfg_data | input | DATA_W | Required data value |
| cmd_run | input | 1 | Resume free running |
| cmd_halt | input | 1 | Stop the CPU |
| cmd_step | input | 1 | Execute one instruction |
| cmd_skip | input | 1 | Skip one instruction |
| insn_bnd | input | 1 | Instruction start strobe |
| pc | input | ADDR_W | Address of the starting instruction |
| bus_valid | input | 1 | Data access strobe |
| bus_write | input | 1 | 1 write, 0 read |
| bus_space | input | 2 | Space of the access |
| bus_addr | input | ADDR_W | Access address |
| bus_data | input | DATA_W | Data written or read back |
| cpu_halt | output | 1 | Halt request to the CPU |
| cpu_skip | output | 1 | Advance without executing |
| hit_valid | output | 1 | A breakpoint caused the current stop |
| hit_slot | output | SLOT_IW | Slot that caused the stop |

## Verification
Every output is a register. A command or a boundary presented in one cycle therefore shows on the outputs right after the next rising edge. A data-access match shows nothing on that edge and appears only after the edge that samples the following `insn_bnd`. The bench holds each stimulus for exactly one edge and samples 1 ns after that edge. It also checks `cpu_halt` after a matching access but before the boundary, to confirm the stop is deferred.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

   typedef enum logic [1:0] {
      SP_PROG  = 2'd0,
      SP_IDATA = 2'd1,
      SP_SFR   = 2'd2,
      SP_XDATA = 2'd3
   } bp_space_e;

   typedef enum logic [1:0] {
      BK_PC  = 2'd0,
      BK_RD  = 2'd1,
      BK_WR  = 2'd2,
      BK_OFF = 2'd3
   } bp_kind_e;

   typedef enum logic [1:0] {
      RS_RUN  = 2'd0,
      RS_HALT = 2'd1,
      RS_STEP = 2'd2,
      RS_SKIP = 2'd3
   } run_state_e;

endpackage

// File: rtl/dbg_bkpt_slot.sv
module dbg_bkpt_slot
   import dbg_bkpt_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter bit DATA_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_enable,
   input  logic [1:0]        wr_space,
   input  logic [1:0]        wr_kind,
   input  logic              wr_dmatch,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              active,
   input  logic              bnd,
   input  logic [ADDR_W-1:0] pc,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [1:0]        bus_space,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              pc_hit,
   output logic              data_hit
);

   logic              en_q;
   bp_space_e         space_q;
   bp_kind_e          kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic              val_ok;
   logic              addr_eq;
   logic              kind_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         space_q <= SP_PROG;
         kind_q  <= BK_PC;
         addr_q  <= '0;
      end else if (wr_en) begin
         en_q    <= wr_enable;
         space_q <= bp_space_e'(wr_space);
         kind_q  <= bp_kind_e'(wr_kind);
         addr_q  <= wr_addr;
      end
   end

   // one shared comparator: operand chosen by slot kind
   assign addr_eq = (((kind_q == BK_PC) ? pc : bus_addr) == addr_q);

   generate
      if (DATA_CMP) begin : g_dcmp
         logic              dm_q;
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dm_q   <= 1'b0;
               data_q <= '0;
            end else if (wr_en) begin
               dm_q   <= wr_dmatch;
               data_q <= wr_data;
            end
         end
         assign val_ok = !dm_q || (bus_data == data_q);
      end else begin : g_nodcmp
         assign val_ok = 1'b1;
      end
   endgenerate

   assign kind_ok = ((kind_q == BK_RD) && !bus_write) ||
                    ((kind_q == BK_WR) &&  bus_write);

   assign pc_hit   = active && en_q && (kind_q == BK_PC) && bnd && addr_eq;
   assign data_hit = active && en_q && bus_valid && kind_ok &&
                     (bp_space_e'(bus_space) == space_q) && addr_eq && val_ok;

endmodule

// File: rtl/dbg_bkpt_first.sv
module dbg_bkpt_first #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign any = |vec;

endmodule

// File: rtl/dbg_bkpt_ctrl.sv
module dbg_bkpt_ctrl
   import dbg_bkpt_pkg::*;
#(
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dbg_en,
   input  logic          cmd_run,
   input  logic          cmd_halt,
   input  logic          cmd_step,
   input  logic          cmd_skip,
   input  logic          bnd,
   input  logic          pc_any,
   input  logic [IW-1:0] pc_idx,
   input  logic          data_any,
   input  logic [IW-1:0] data_idx,
   output logic          cpu_halt,
   output logic          cpu_skip,
   output logic          hit_valid,
   output logic [IW-1:0] hit_slot
);

   run_state_e    st_q, st_d;
   logic          supp_q, supp_d;
   logic          seen_q, seen_d;
   logic          pend_q, pend_d;
   logic [IW-1:0] pidx_q, pidx_d;
   logic          hit_d;
   logic [IW-1:0] hidx_d;
   logic          pc_ok;

   assign pc_ok = pc_any && !supp_q;

   always_comb begin
      st_d   = st_q;
      supp_d = supp_q;
      seen_d = seen_q;
      pend_d = pend_q;
      pidx_d = pidx_q;
      hit_d  = hit_valid;
      hidx_d = hit_slot;
      if (!dbg_en) begin
         st_d   = RS_RUN;
         supp_d = 1'b0;
         seen_d = 1'b0;
         pend_d = 1'b0;
         hit_d  = 1'b0;
      end else if (st_q == RS_HALT) begin
         pend_d = 1'b0;
         seen_d = 1'b0;
         if (cmd_run || cmd_step || cmd_skip) begin
            supp_d = 1'b1;
            hit_d  = 1'b0;
            if (cmd_run)       st_d = RS_RUN;
            else if (cmd_step) st_d = RS_STEP;
            else               st_d = RS_SKIP;
         end
      end else if (cmd_halt) begin
         st_d   = RS_HALT;
         pend_d = 1'b0;
      end else if (bnd) begin
         supp_d = 1'b0;
         seen_d = 1'b1;
         if (pend_q) begin
            st_d   = RS_HALT;
            hit_d  = 1'b1;
            hidx_d = pidx_q;
         end else if (pc_ok) begin
            st_d   = RS_HALT;
            hit_d  = 1'b1;
            hidx_d = pc_idx;
         end else if ((st_q != RS_RUN) && seen_q) begin
            st_d = RS_HALT;
         end
         pend_d = (st_d != RS_HALT) && data_any;
         pidx_d = data_idx;
      end else if (data_any && !pend_q) begin
         pend_d = 1'b1;
         pidx_d = data_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= RS_RUN;
         supp_q    <= 1'b0;
         seen_q    <= 1'b0;
         pend_q    <= 1'b0;
         pidx_q    <= '0;
         hit_valid <= 1'b0;
         hit_slot  <= '0;
      end else begin
         st_q      <= st_d;
         supp_q    <= supp_d;
         seen_q    <= seen_d;
         pend_q    <= pend_d;
         pidx_q    <= pidx_d;
         hit_valid <= hit_d;
         hit_slot  <= hidx_d;
      end
   end

   assign cpu_halt = (st_q == RS_HALT);
   assign cpu_skip = (st_q == RS_SKIP);

   assert_halt_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_en && cmd_halt && !cmd_run && !cmd_step && !cmd_skip) |=> cpu_halt);

   assert_off_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_en |=> (!cpu_halt && !cpu_skip && !hit_valid));

   assert_step_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_en && cpu_halt && cmd_step && !cmd_run) |=> (!cpu_halt && !cpu_skip));

   assert_skip_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_en && cpu_halt && cmd_skip && !cmd_run && !cmd_step) |=> (cpu_skip && !cpu_halt));

   assert_resume_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_en && cpu_halt && cmd_run) |=> (!cpu_halt && !hit_valid));

   assert_hit_only_halted_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> cpu_halt);

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
   import dbg_bkpt_pkg::*;
#(
   parameter int  NSLOT    = 4,
   parameter int  ADDR_W   = 24,
   parameter int  DATA_W   = 8,
   parameter bit  DATA_CMP = 1'b1,
   localparam int SLOT_IW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dbg_en,
   input  logic               cfg_we,
   input  logic [SLOT_IW-1:0] cfg_slot,
   input  logic               cfg_enable,
   input  logic [1:0]         cfg_space,
   input  logic [1:0]         cfg_kind,
   input  logic               cfg_dmatch,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [DATA_W-1:0]  cfg_data,
   input  logic               cmd_run,
   input  logic               cmd_halt,
   input  logic               cmd_step,
   input  logic               cmd_skip,
   input  logic               insn_bnd,
   input  logic [ADDR_W-1:0]  pc,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [1:0]         bus_space,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_data,
   output logic               cpu_halt,
   output logic               cpu_skip,
   output logic               hit_valid,
   output logic [SLOT_IW-1:0] hit_slot
);

   generate
      if (NSLOT < 1 || NSLOT > 16) begin : g_bad_nslot
         $error("dbg_bkpt_unit: NSLOT must be 1..16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("dbg_bkpt_unit: ADDR_W must be 8..32");
      end
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
         $error("dbg_bkpt_unit: DATA_W must be 1..32");
      end
   endgenerate

   logic [NSLOT-1:0]   pc_vec;
   logic [NSLOT-1:0]   data_vec;
   logic               pc_any, data_any;
   logic [SLOT_IW-1:0] pc_idx, data_idx;
   logic               active;

   assign active = dbg_en && !cpu_halt;

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         dbg_bkpt_slot #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .DATA_CMP(DATA_CMP)
         ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_slot == SLOT_IW'(s))),
            .wr_enable (cfg_enable),
            .wr_space  (cfg_space),
            .wr_kind   (cfg_kind),
            .wr_dmatch (cfg_dmatch),
            .wr_addr   (cfg_addr),
            .wr_data   (cfg_data),
            .active    (active),
            .bnd       (insn_bnd),
            .pc        (pc),
            .bus_valid (bus_valid),
            .bus_write (bus_write),
            .bus_space (bus_space),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .pc_hit    (pc_vec[s]),
            .data_hit  (data_vec[s])
         );
      end
   endgenerate

   dbg_bkpt_first #(.N(NSLOT), .IW(SLOT_IW)) u_pc_first (
      .vec(pc_vec), .any(pc_any), .idx(pc_idx)
   );

   dbg_bkpt_first #(.N(NSLOT), .IW(SLOT_IW)) u_data_first (
      .vec(data_vec), .any(data_any), .idx(data_idx)
   );

   dbg_bkpt_ctrl #(.IW(SLOT_IW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .dbg_en    (dbg_en),
      .cmd_run   (cmd_run),
      .cmd_halt  (cmd_halt),
      .cmd_step  (cmd_step),
      .cmd_skip  (cmd_skip),
      .bnd       (insn_bnd),
      .pc_any    (pc_any),
      .pc_idx    (pc_idx),
      .data_any  (data_any),
      .data_idx  (data_idx),
      .cpu_halt  (cpu_halt),
      .cpu_skip  (cpu_skip),
      .hit_valid (hit_valid),
      .hit_slot  (hit_slot)
   );

   assert_idle_nomatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_en |-> (pc_vec == '0 && data_vec == '0));

   assert_hit_slot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (int'(hit_slot) < NSLOT));

endmodule

// File: tb/tb_dbg_bkpt_unit.sv
module tb_dbg_bkpt_unit;

   localparam int AW = 24;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dbg_en = 1'b1;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_slot = '0;
   logic          cfg_enable = 1'b0;
   logic [1:0]    cfg_space = '0;
   logic [1:0]    cfg_kind = '0;
   logic          cfg_dmatch = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_data = '0;
   logic          cmd_run = 1'b0, cmd_halt = 1'b0, cmd_step = 1'b0, cmd_skip = 1'b0;
   logic          insn_bnd = 1'b0;
   logic [AW-1:0] pc = '0;
   logic          bus_valid = 1'b0, bus_write = 1'b0;
   logic [1:0]    bus_space = '0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_data = '0;
   logic          cpu_halt, cpu_skip, hit_valid;
   logic [1:0]    hit_slot;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dbg_bkpt_unit dut (
      .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_enable(cfg_enable),
      .cfg_space(cfg_space), .cfg_kind(cfg_kind), .cfg_dmatch(cfg_dmatch),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .cmd_run(cmd_run), .cmd_halt(cmd_halt), .cmd_step(cmd_step), .cmd_skip(cmd_skip),
      .insn_bnd(insn_bnd), .pc(pc),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_space(bus_space),
      .bus_addr(bus_addr), .bus_data(bus_data),
      .cpu_halt(cpu_halt), .cpu_skip(cpu_skip),
      .hit_valid(hit_valid), .hit_slot(hit_slot)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_out(string req, logic h, logic s, logic hv);
      chk(req, "cpu_halt", 32'(cpu_halt), 32'(h));
      chk(req, "cpu_skip", 32'(cpu_skip), 32'(s));
      chk(req, "hit_valid", 32'(hit_valid), 32'(hv));
   endtask

   task automatic cfg(int slot, bit en, int sp, int kind, bit dm, int addr, int data);
      cfg_slot = 2'(slot); cfg_enable = en; cfg_space = 2'(sp); cfg_kind = 2'(kind);
      cfg_dmatch = dm; cfg_addr = AW'(addr); cfg_data = DW'(data);
      cfg_we = 1'b1;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic bnd(int pcv);
      insn_bnd = 1'b1; pc = AW'(pcv);
      tick();
      insn_bnd = 1'b0;
   endtask

   task automatic acc(int sp, bit wr, int addr, int data);
      bus_valid = 1'b1; bus_space = 2'(sp); bus_write = wr;
      bus_addr = AW'(addr); bus_data = DW'(data);
      tick();
      bus_valid = 1'b0;
   endtask

   task automatic do_run();  cmd_run = 1'b1;  tick(); cmd_run = 1'b0;  endtask
   task automatic do_halt(); cmd_halt = 1'b1; tick(); cmd_halt = 1'b0; endtask
   task automatic do_step(); cmd_step = 1'b1; tick(); cmd_step = 1'b0; endtask
   task automatic do_skip(); cmd_skip = 1'b1; tick(); cmd_skip = 1'b0; endtask

   task automatic t_reset();
      chk_out("R11", 1'b0, 1'b0, 1'b0);
      bnd(0);
      chk("R11", "halt, all slots disabled", 32'(cpu_halt), 0);
   endtask

   task automatic t_pc();
      cfg(1, 1, 0, 0, 0, 'h1234, 0);
      bnd('h1230);
      chk("R1", "halt on other pc", 32'(cpu_halt), 0);
      bnd('h1234);
      chk_out("R1", 1'b1, 1'b0, 1'b1);
      chk("R1", "hit_slot", 32'(hit_slot), 1);
   endtask

   task automatic t_run();
      do_run();
      chk_out("R7", 1'b0, 1'b0, 1'b0);
      bnd('h1234);
      chk("R7", "first boundary suppressed", 32'(cpu_halt), 0);
      bnd('h1236);
      chk("R7", "halt at 1236", 32'(cpu_halt), 0);
      bnd('h1234);
      chk("R7", "later match halts", 32'(cpu_halt), 1);
      chk("R7", "hit_slot", 32'(hit_slot), 1);
   endtask

   task automatic t_step();
      do_step();
      chk_out("R8", 1'b0, 1'b0, 1'b0);
      bnd('h1234);
      chk("R8", "first boundary runs", 32'(cpu_halt), 0);
      bnd('h1237);
      chk_out("R8", 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_skip();
      do_skip();
      chk_out("R9", 1'b0, 1'b1, 1'b0);
      bnd('h1237);
      chk_out("R9", 1'b0, 1'b1, 1'b0);
      bnd('h1238);
      chk_out("R9", 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_data_write();
      cfg(2, 1, 3, 2, 0, 'hABCD, 0);
      do_run();
      bnd('h100);
      acc(1, 1'b1, 'hABCD, 0);
      bnd('h101);
      chk("R4", "write in wrong space", 32'(cpu_halt), 0);
      acc(3, 1'b0, 'hABCD, 0);
      bnd('h102);
      chk("R2", "read on write slot", 32'(cpu_halt), 0);
      acc(3, 1'b1, 'hABCD, 'h77);
      chk("R2", "halt deferred to boundary", 32'(cpu_halt), 0);
      bnd('h103);
      chk("R2", "write hit halts", 32'(cpu_halt), 1);
      chk("R2", "hit_slot", 32'(hit_slot), 2);
   endtask

   task automatic t_data_value();
      cfg(3, 1, 2, 1, 1, 'h90, 'h5A);
      do_run();
      bnd('h200);
      acc(2, 1'b0, 'h90, 'h11);
      bnd('h201);
      chk("R3", "wrong data value", 32'(cpu_halt), 0);
      acc(2, 1'b0, 'h90, 'h5A);
      bnd('h202);
      chk("R3", "matching data value", 32'(cpu_halt), 1);
      chk("R3", "hit_slot", 32'(hit_slot), 3);
   endtask

   task automatic t_prio();
      cfg(0, 1, 0, 0, 0, 'h2000, 0);
      cfg(1, 1, 0, 0, 0, 'h2000, 0);
      do_run();
      bnd('h3000);
      bnd('h2000);
      chk("R5", "halt on shared pc", 32'(cpu_halt), 1);
      chk("R5", "lowest slot wins", 32'(hit_slot), 0);
      do_run();
      bnd('h3000);
      acc(2, 1'b0, 'h90, 'h5A);
      bnd('h2000);
      chk("R5", "halt", 32'(cpu_halt), 1);
      chk("R5", "pending data beats pc", 32'(hit_slot), 3);
   endtask

   task automatic t_kind_off();
      cfg(0, 1, 0, 3, 0, 'h4000, 0);
      cfg(1, 0, 0, 0, 0, 'h4000, 0);
      do_run();
      bnd('h3000);
      bnd('h4000);
      chk("R12", "kind 3 / disabled pc slot", 32'(cpu_halt), 0);
      acc(0, 1'b0, 'h4000, 0);
      bnd('h4001);
      chk("R12", "kind 3 on read", 32'(cpu_halt), 0);
   endtask

   task automatic t_halt();
      do_halt();
      chk_out("R6", 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_off();
      dbg_en = 1'b0;
      tick();
      chk_out("R10", 1'b0, 1'b0, 1'b0);
      do_halt();
      chk("R10", "halt ignored", 32'(cpu_halt), 0);
      cfg(2, 1, 0, 0, 0, 'h5000, 0);
      bnd('h5000);
      chk("R10", "no match while off", 32'(cpu_halt), 0);
      dbg_en = 1'b1;
      bnd('h5000);
      chk("R10", "config kept, match after enable", 32'(cpu_halt), 1);
      chk("R10", "hit_slot", 32'(hit_slot), 2);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_pc();
      t_run();
      t_step();
      t_skip();
      t_data_write();
      t_data_value();
      t_prio();
      t_kind_off();
      t_halt();
      t_off();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule